// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block connects a simple host request port to one single-data-rate SDRAM device of four banks. The host offers one request at a time: a read or write flag, a linear word address, a 16-bit write word with two byte masks. The controller accepts the request when it is idle, opens the addressed row, issues a single-word read or write with auto-precharge, and returns read words as a one-cycle valid pulse with data. Only one row is open at any time, and it is closed again by the access itself.

After reset the controller holds the clock enable low, then waits a stabilisation period. It then precharges all banks, runs two auto-refresh cycles and programs the mode register before it accepts any request. The CAS latency (2 or 3) is a runtime input that is written into the mode register and sets the cycle in which read data is captured. A refresh timer derived from the clock frequency spreads 4096 auto-refresh commands over every 64 ms. A refresh that falls due wins over a waiting host request at the next free slot.

Top module: `sdr_controller`

## Requirements
- R1: While reset is held, sdCke is 0, the command pins show NOP, and reqReady and rdValid are 0.
- R2: Commands are coded on {sdCsN,sdRasN,sdCasN,sdWeN}: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 auto refresh, 0000 load mode, 0111 NOP. After reset the first commands are precharge with sdAddr[10]=1, auto refresh, auto refresh, load mode, in that order, and reqReady is never 1 before load mode has been issued.
- R3: The load mode word on sdAddr has bits [2:0]=000 (one-word bursts), bit 3 = BURST_INTERLEAVE, bits [6:4] = {0, casLat} and all other bits 0.
- R4: reqAddr is split as row = [22:11], bank = [10:9], column = [8:0]. Activate carries the row on sdAddr and the bank on sdBa; the following read or write carries the same bank, the column on sdAddr[8:0] and sdAddr[10]=1. In the write command cycle sdDqOut holds the write word and sdDqm equals reqMask (bit 0 masks the low byte, bit 1 the high byte).
- R5: The word present on sdDqIn at the casLat-th rising edge after the edge that samples a read command is delivered on rdData, with rdValid high for exactly one cycle, so rdValid is seen at the casLat+1-th edge.
- R6: A read or write command follows its activate by exactly T_RCD clock edges.
- R7: Refresh interval is REF_INTERVAL = CLK_MHZ*64000/4096 clocks (integer division); after initialisation no two auto refresh commands are more than REF_INTERVAL+T_RC+T_RCD+T_RP+4 edges apart, even under back-to-back host traffic.
- R8: Any activate or auto refresh command is at least T_RC edges after the previous activate or auto refresh.
- R9: sdDqOe is 1 exactly in write command cycles.
- R10: A due refresh takes priority over a waiting request: reqReady is 0 while a refresh is pending, so a host holding reqValid high cannot starve refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all pins change on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| casLat | input | 2 | CAS latency, 2 or 3, held stable; programmed at initialisation |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller accepts the request in this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 23 | Linear word address {row, bank, column} |
| reqWdata | input | 16 | Write word |
| reqMask | input | 2 | Per-byte write mask, 1 = byte not written |
| rdValid | output | 1 | One-cycle read data valid |
| rdData | output | 16 | Read word |
| sdCke | output | 1 | Clock enable to the device |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 2 | Bank address |
| sdAddr | output | 12 | Row / column / mode address |
| sdDqm | output | 2 | Byte masks, bit 0 low byte |
| sdDqOut | output | 16 | Data driven to the device |
| sdDqOe | output | 1 | Output enable for sdDqOut |
| sdDqIn | input | 16 | Data returned by the device |

## Verification
The refresh timer and the host request path can both want the command bus in the same idle cycle. This is provoked by holding reqValid high across many back-to-back writes while the refresh interval is made short (CLK_MHZ=4, 62 clocks), so that refresh deadlines keep landing while a request waits. It is judged by the gap between consecutive refresh commands staying inside the R7 bound, by the number of refreshes over the stream, and by the activate-to-refresh spacing staying at least T_RC.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_MODE = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_ACT  = 4'b0011,
    CMD_WR   = 4'b0100,
    CMD_RD   = 4'b0101,
    CMD_NOP  = 4'b0111
  } sdCmd_e;

  // control -> datapath strobes, one per cycle
  typedef struct packed {
    sdCmd_e cmd;
    logic   accept;
  } strobe_t;

endpackage

// File: rtl/sdr_ctrl.sv
module sdr_ctrl
  import sdr_pkg::*;
#(
  parameter int INIT_CYCLES  = 25000,
  parameter int REF_INTERVAL = 1953,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 3,
  parameter int T_RC         = 7,
  parameter int T_WR         = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  // gaps counted from the read/write command; reads leave room for CL=3
  localparam int RC_REST = T_RC - T_RCD;
  localparam int RD_GAP  = (RC_REST > T_RP + 4) ? RC_REST : T_RP + 4;
  localparam int WR_GAP  = (RC_REST > T_WR + T_RP) ? RC_REST : T_WR + T_RP;
  localparam int CNT_W   = $clog2(INIT_CYCLES + RD_GAP + WR_GAP + T_RC + 2);
  localparam int REF_W   = $clog2(REF_INTERVAL + 1);

  typedef enum logic [2:0] {
    ST_WAIT, ST_PRE, ST_REF1, ST_REF2, ST_MODE, ST_IDLE, ST_RW
  } state_e;

  state_e             state, stateN, afterSt, afterN;
  logic [CNT_W-1:0]   waitCnt, cntN;
  logic [REF_W-1:0]   refCnt;
  logic               refPending, refClr, refWrap, isWrite;

  assign refWrap  = (refCnt == REF_W'(REF_INTERVAL - 1));
  assign reqReady = (state == ST_IDLE) && !refPending;

  always_comb begin
    stb.cmd    = CMD_NOP;
    stb.accept = 1'b0;
    stateN     = state;
    afterN     = afterSt;
    cntN       = waitCnt;
    refClr     = 1'b0;
    case (state)
      ST_WAIT: begin
        cntN = waitCnt - 1'b1;
        if (waitCnt == CNT_W'(1)) stateN = afterSt;
      end
      ST_PRE: begin
        stb.cmd = CMD_PRE;
        stateN = ST_WAIT; cntN = CNT_W'(T_RP - 1); afterN = ST_REF1;
      end
      ST_REF1: begin
        stb.cmd = CMD_REF;
        stateN = ST_WAIT; cntN = CNT_W'(T_RC - 1); afterN = ST_REF2;
      end
      ST_REF2: begin
        stb.cmd = CMD_REF;
        stateN = ST_WAIT; cntN = CNT_W'(T_RC - 1); afterN = ST_MODE;
      end
      ST_MODE: begin
        stb.cmd = CMD_MODE;
        stateN = ST_WAIT; cntN = CNT_W'(1); afterN = ST_IDLE;
      end
      ST_IDLE: begin
        if (refPending) begin
          stb.cmd = CMD_REF;
          refClr  = 1'b1;
          stateN = ST_WAIT; cntN = CNT_W'(T_RC - 1); afterN = ST_IDLE;
        end else if (reqValid) begin
          stb.cmd    = CMD_ACT;
          stb.accept = 1'b1;
          stateN = ST_WAIT; cntN = CNT_W'(T_RCD - 1); afterN = ST_RW;
        end
      end
      ST_RW: begin
        stb.cmd = isWrite ? CMD_WR : CMD_RD;
        stateN  = ST_WAIT;
        cntN    = isWrite ? CNT_W'(WR_GAP - 1) : CNT_W'(RD_GAP - 1);
        afterN  = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_WAIT;
      afterSt    <= ST_PRE;
      waitCnt    <= CNT_W'(INIT_CYCLES);
      refCnt     <= '0;
      refPending <= 1'b0;
      isWrite    <= 1'b0;
    end else begin
      state   <= stateN;
      afterSt <= afterN;
      waitCnt <= cntN;
      if (stb.accept) isWrite <= reqWrite;
      refCnt <= refWrap ? '0 : refCnt + 1'b1;
      if (refWrap)     refPending <= 1'b1;
      else if (refClr) refPending <= 1'b0;
    end
  end

endmodule

// File: rtl/sdr_datapath.sv
module sdr_datapath
  import sdr_pkg::*;
#(
  parameter int ROW_W            = 12,
  parameter int BANK_W           = 2,
  parameter int COL_W            = 9,
  parameter int DATA_W           = 16,
  parameter bit BURST_INTERLEAVE = 1'b0
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  strobe_t                           stb,
  input  logic [1:0]                        casLat,
  input  logic [ROW_W+BANK_W+COL_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]                 reqWdata,
  input  logic [DATA_W/8-1:0]               reqMask,
  input  logic [DATA_W-1:0]                 sdDqIn,
  output logic [3:0]                        cmdPins,
  output logic                              sdCke,
  output logic [BANK_W-1:0]                 sdBa,
  output logic [ROW_W-1:0]                  sdAddr,
  output logic [DATA_W/8-1:0]               sdDqm,
  output logic [DATA_W-1:0]                 sdDqOut,
  output logic                              sdDqOe,
  output logic                              rdValid,
  output logic [DATA_W-1:0]                 rdData
);

  localparam int MASK_W = DATA_W / 8;
  localparam int AP_BIT = 10;

  logic [BANK_W-1:0] bankQ, baN;
  logic [COL_W-1:0]  colQ;
  logic [DATA_W-1:0] dataQ;
  logic [MASK_W-1:0] maskQ;
  logic [ROW_W-1:0]  aN;
  logic [1:0]        clReg;
  logic [2:0]        rdPipe;
  logic              capture;

  always_comb begin
    aN  = '0;
    baN = bankQ;
    case (stb.cmd)
      CMD_ACT: begin
        aN  = reqAddr[COL_W+BANK_W +: ROW_W];
        baN = reqAddr[COL_W +: BANK_W];
      end
      CMD_RD, CMD_WR: begin
        aN[COL_W-1:0] = colQ;
        aN[AP_BIT]    = 1'b1;
      end
      CMD_PRE: aN[AP_BIT] = 1'b1;
      CMD_MODE: begin
        aN[3]   = BURST_INTERLEAVE;
        aN[6:4] = {1'b0, casLat};
      end
      default: aN = '0;
    endcase
  end

  assign capture = (clReg == 2'd3) ? rdPipe[2] : rdPipe[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPins <= CMD_NOP;
      sdCke   <= 1'b0;
      sdBa    <= '0;
      sdAddr  <= '0;
      sdDqm   <= '0;
      sdDqOut <= '0;
      sdDqOe  <= 1'b0;
      bankQ   <= '0;
      colQ    <= '0;
      dataQ   <= '0;
      maskQ   <= '0;
      clReg   <= 2'd3;
      rdPipe  <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      sdCke   <= 1'b1;
      cmdPins <= stb.cmd;
      sdBa    <= baN;
      sdAddr  <= aN;
      sdDqm   <= (stb.cmd == CMD_WR) ? maskQ : '0;
      sdDqOut <= dataQ;
      sdDqOe  <= (stb.cmd == CMD_WR);
      if (stb.accept) begin
        bankQ <= reqAddr[COL_W +: BANK_W];
        colQ  <= reqAddr[COL_W-1:0];
        dataQ <= reqWdata;
        maskQ <= reqMask;
      end
      if (stb.cmd == CMD_MODE) clReg <= casLat;
      rdPipe  <= {rdPipe[1:0], cmdPins == CMD_RD};
      rdValid <= capture;
      if (capture) rdData <= sdDqIn;
    end
  end

endmodule

// File: rtl/sdr_controller.sv
module sdr_controller
  import sdr_pkg::*;
#(
  parameter int CLK_MHZ          = 125,
  parameter int INIT_CYCLES      = 25000,
  parameter int T_RCD            = 2,
  parameter int T_RP             = 3,
  parameter int T_RC             = 7,
  parameter int T_WR             = 2,
  parameter bit BURST_INTERLEAVE = 1'b0,
  parameter int ROW_W            = 12,
  parameter int BANK_W           = 2,
  parameter int COL_W            = 9,
  parameter int DATA_W           = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    casLat,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic                          reqWrite,
  input  logic [ROW_W+BANK_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic [DATA_W/8-1:0]           reqMask,
  output logic                          rdValid,
  output logic [DATA_W-1:0]             rdData,
  output logic                          sdCke,
  output logic                          sdCsN,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic [BANK_W-1:0]             sdBa,
  output logic [ROW_W-1:0]              sdAddr,
  output logic [DATA_W/8-1:0]           sdDqm,
  output logic [DATA_W-1:0]             sdDqOut,
  output logic                          sdDqOe,
  input  logic [DATA_W-1:0]             sdDqIn
);

  // 4096 refreshes per 64 ms
  localparam int REF_INTERVAL = (CLK_MHZ * 64000) / 4096;

  strobe_t    stb;
  logic [3:0] cmdPins;

  sdr_ctrl #(
    .INIT_CYCLES(INIT_CYCLES), .REF_INTERVAL(REF_INTERVAL),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_WR(T_WR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  sdr_datapath #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .BURST_INTERLEAVE(BURST_INTERLEAVE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .casLat(casLat), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqMask(reqMask), .sdDqIn(sdDqIn),
    .cmdPins(cmdPins), .sdCke(sdCke), .sdBa(sdBa), .sdAddr(sdAddr),
    .sdDqm(sdDqm), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe),
    .rdValid(rdValid), .rdData(rdData)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdPins;

endmodule

// File: rtl/sdr_checker.sv
module sdr_checker #(
  parameter int ROW_W     = 12,
  parameter int T_RC      = 7,
  parameter int T_RCD     = 2,
  parameter int REF_LIMIT = 2000
) (
  input logic             clk,
  input logic             rstN,
  input logic             sdCsN,
  input logic             sdRasN,
  input logic             sdCasN,
  input logic             sdWeN,
  input logic [ROW_W-1:0] sdAddr,
  input logic             sdDqOe,
  input logic [1:0]       casLat,
  input logic             rdValid,
  input logic             reqReady
);

  logic [3:0]  cmd;
  logic [7:0]  sinceRow, sinceAct;
  logic [31:0] sinceRef;
  logic        modeSeen, refSeen;
  logic        isAct, isRef, isRw;

  assign cmd   = {sdCsN, sdRasN, sdCasN, sdWeN};
  assign isAct = (cmd == 4'b0011);
  assign isRef = (cmd == 4'b0001);
  assign isRw  = (cmd == 4'b0101) || (cmd == 4'b0100);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRow <= 8'hFF;
      sinceAct <= 8'hFF;
      sinceRef <= '0;
      modeSeen <= 1'b0;
      refSeen  <= 1'b0;
    end else begin
      sinceRow <= (isAct || isRef) ? 8'd0 : ((sinceRow == 8'hFF) ? sinceRow : sinceRow + 8'd1);
      sinceAct <= isAct ? 8'd0 : ((sinceAct == 8'hFF) ? sinceAct : sinceAct + 8'd1);
      if (cmd == 4'b0000) modeSeen <= 1'b1;
      if (isRef) begin
        refSeen  <= 1'b1;
        sinceRef <= '0;
      end else begin
        sinceRef <= sinceRef + 32'd1;
      end
    end
  end

  // R9
  dq_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> (cmd == 4'b0100));

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R8
  row_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isAct || isRef) |-> (32'(sinceRow) + 32'd1 >= 32'(T_RC)));

  // R6
  rcd_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRw |-> (32'(sinceAct) + 32'd1 == 32'(T_RCD)));

  // R3
  mode_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'b0000) |-> (sdAddr[6:4] == {1'b0, casLat} && sdAddr[2:0] == 3'b000));

  // R2
  init_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> modeSeen);

  // R7
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refSeen && modeSeen) |-> (sinceRef < 32'(REF_LIMIT)));

endmodule

bind sdr_controller sdr_checker #(
  .ROW_W(ROW_W), .T_RC(T_RC), .T_RCD(T_RCD),
  .REF_LIMIT(REF_INTERVAL + T_RC + T_RCD + T_RP + 4)
) u_chk (
  .clk(clk), .rstN(rstN), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
  .sdWeN(sdWeN), .sdAddr(sdAddr), .sdDqOe(sdDqOe), .casLat(casLat),
  .rdValid(rdValid), .reqReady(reqReady)
);

// File: tb/test_sdr_controller.sv
`timescale 1ns/1ps
module test_sdr_controller;

  localparam int CLK_MHZ   = 4;
  localparam int INIT_CYC  = 20;
  localparam int T_RCD     = 2;
  localparam int T_RP      = 3;
  localparam int T_RC      = 7;
  localparam int T_WR      = 2;
  localparam int REF_INT   = (CLK_MHZ * 64000) / 4096;
  localparam int REF_LIMIT = REF_INT + T_RC + T_RCD + T_RP + 4;
  localparam int NVEC      = 10;

  // {write, addr[22:0], data, mask, expected read}
  localparam logic [57:0] VEC [NVEC] = '{
    {1'b1, 23'h000005, 16'h1234, 2'b00, 16'h0000},
    {1'b1, 23'h7FFFFF, 16'hBEEF, 2'b00, 16'h0000},
    {1'b1, 23'h000200, 16'h5A5A, 2'b00, 16'h0000},
    {1'b1, 23'h000005, 16'hFFFF, 2'b01, 16'h0000},
    {1'b1, 23'h000200, 16'h0000, 2'b10, 16'h0000},
    {1'b0, 23'h000005, 16'h0000, 2'b00, 16'hFF34},
    {1'b0, 23'h7FFFFF, 16'h0000, 2'b00, 16'hBEEF},
    {1'b0, 23'h000200, 16'h0000, 2'b00, 16'h5A00},
    {1'b1, 23'h400600, 16'hC3C3, 2'b00, 16'h0000},
    {1'b0, 23'h400600, 16'h0000, 2'b00, 16'hC3C3}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  casLat = 2'd3;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [22:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        reqReady, rdValid, sdCke, sdCsN, sdRasN, sdCasN, sdWeN, sdDqOe;
  logic [15:0] rdData, sdDqOut;
  logic [15:0] sdDqIn = '0;
  logic [1:0]  sdBa, sdDqm;
  logic [11:0] sdAddr;

  int nChecks = 0, nErr = 0;
  bit done = 1'b0;

  sdr_controller #(
    .CLK_MHZ(CLK_MHZ), .INIT_CYCLES(INIT_CYC), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RC(T_RC), .T_WR(T_WR), .BURST_INTERLEAVE(1'b1)
  ) i_sdr_controller (
    .clk(clk), .rstN(rstN), .casLat(casLat), .reqValid(reqValid),
    .reqReady(reqReady), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqMask(reqMask), .rdValid(rdValid), .rdData(rdData),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm),
    .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model and bus monitor ----------------
  logic [3:0]  cmd;
  assign cmd = {sdCsN, sdRasN, sdCasN, sdWeN};

  logic [15:0] memModel [logic [22:0]];
  int          cyc = 0, actCyc = 0, rdCyc = 0, lastRef = 0, lastRow = -1000;
  int          refTotal = 0, seqN = 0, rdCnt = 0, clTb = 3;
  bit          initDone = 1'b0;
  logic [3:0]  seq [4];
  logic        preA10 = 1'b0;
  logic [11:0] modeWord = '0, actRow = '0;
  logic [1:0]  actBank = '0;
  logic [22:0] accAddr = '0, rdKey = '0;
  logic [15:0] accData = '0;
  logic [1:0]  accMask = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      seqN = 0; initDone = 1'b0; rdCnt = 0; lastRow = -1000;
    end else begin
      cyc++;
      if (!initDone && cmd != 4'b0111 && seqN < 4) begin
        seq[seqN] = cmd;
        if (cmd == 4'b0010) preA10 = sdAddr[10];
        seqN++;
      end
      if (cmd == 4'b0011 || cmd == 4'b0001) begin
        chk(cyc - lastRow >= T_RC, "R8", "row command spacing", cyc - lastRow, T_RC);
        lastRow = cyc;
      end
      case (cmd)
        4'b0000: begin modeWord = sdAddr; initDone = 1'b1; end
        4'b0011: begin
          chk(sdBa == accAddr[10:9] && sdAddr == accAddr[22:11], "R4", "activate row/bank",
              {sdBa, sdAddr}, {accAddr[10:9], accAddr[22:11]});
          actCyc = cyc; actRow = sdAddr; actBank = sdBa;
        end
        4'b0100: begin
          logic [22:0] k;
          logic [15:0] old;
          chk(cyc - actCyc == T_RCD, "R6", "activate to write", cyc - actCyc, T_RCD);
          chk(sdAddr[10] && sdAddr[8:0] == accAddr[8:0] && sdBa == actBank, "R4",
              "write column", sdAddr, {3'b001, accAddr[8:0]});
          chk(sdDqm == accMask && sdDqOut == accData, "R4", "write data/mask",
              {sdDqm, sdDqOut}, {accMask, accData});
          chk(sdDqOe, "R9", "oe in write", sdDqOe, 1);
          k   = {actBank, actRow, sdAddr[8:0]};
          old = memModel.exists(k) ? memModel[k] : 16'h0000;
          memModel[k] = {sdDqm[1] ? old[15:8] : sdDqOut[15:8],
                         sdDqm[0] ? old[7:0]  : sdDqOut[7:0]};
        end
        4'b0101: begin
          chk(cyc - actCyc == T_RCD, "R6", "activate to read", cyc - actCyc, T_RCD);
          chk(sdAddr[10] && sdAddr[8:0] == accAddr[8:0] && sdBa == actBank, "R4",
              "read column", sdAddr, {3'b001, accAddr[8:0]});
          chk(!sdDqOe, "R9", "oe in read", sdDqOe, 0);
          rdKey = {actBank, actRow, sdAddr[8:0]};
          rdCyc = cyc;
        end
        4'b0001: begin
          if (initDone)
            chk(cyc - lastRef <= REF_LIMIT, "R7", "refresh gap", cyc - lastRef, REF_LIMIT);
          lastRef = cyc;
          refTotal++;
        end
        default: ;
      endcase
      if (rdValid)
        chk(cyc - rdCyc == clTb + 1, "R5", "read latency", cyc - rdCyc, clTb + 1);
      if (cmd == 4'b0101) rdCnt = clTb;
      else if (rdCnt > 0) rdCnt--;
      if (reqValid && reqReady) begin
        accAddr = reqAddr; accData = reqWdata; accMask = reqMask;
      end
    end
  end

  always @(negedge clk)
    sdDqIn <= (rdCnt == 1) ? (memModel.exists(rdKey) ? memModel[rdKey] : 16'h0000) : 16'hDEAD;

  // ---------------- host driver ----------------
  task automatic doReq(input bit wr, input logic [22:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readBack(input logic [15:0] exp, input string what);
    while (!rdValid) @(negedge clk);
    chk(rdData == exp, "R5", what, rdData, exp);
    @(negedge clk);
  endtask

  initial begin
    for (int pass = 0; pass < 2; pass++) begin
      clTb   = (pass == 0) ? 3 : 2;
      casLat = 2'(clTb);
      rstN   = 1'b0;
      reqValid = 1'b0;
      repeat (4) @(negedge clk);
      chk(sdCke == 1'b0, "R1", "cke in reset", sdCke, 0);
      chk(cmd == 4'b0111, "R1", "command in reset", cmd, 4'b0111);
      chk(!reqReady && !rdValid, "R1", "ready/valid in reset", {reqReady, rdValid}, 0);
      memModel.delete();
      rstN = 1'b1;
      while (!reqReady) @(negedge clk);
      chk(initDone, "R2", "ready before load mode", initDone, 1);
      chk(seqN == 4 && seq[0] == 4'b0010 && seq[1] == 4'b0001 && seq[2] == 4'b0001
          && seq[3] == 4'b0000, "R2", "init order",
          {seq[0], seq[1], seq[2], seq[3]}, 16'h2110);
      chk(preA10, "R2", "precharge all flag", preA10, 1);
      chk(modeWord == (12'(clTb) << 4 | 12'h008), "R3", "mode word",
          modeWord, (12'(clTb) << 4 | 12'h008));
      for (int v = 0; v < NVEC; v++) begin
        doReq(VEC[v][57], VEC[v][56:34], VEC[v][33:18], VEC[v][17:16]);
        reqValid = 1'b0;
        if (!VEC[v][57]) readBack(VEC[v][15:0], "table read");
      end
    end

    // refresh against a host that never lets go (R10, R7)
    begin
      int startCyc, startRefs;
      startCyc  = cyc;
      startRefs = refTotal;
      for (int i = 0; i < 40; i++)
        doReq(1'b1, (23'(i) << 11) | 23'(i), 16'(16'hA000 + i), 2'b00);
      reqValid = 1'b0;
      chk(refTotal - startRefs >= (cyc - startCyc) / REF_INT - 1, "R10",
          "refreshes under stream", refTotal - startRefs, (cyc - startCyc) / REF_INT - 1);
      doReq(1'b0, (23'd39 << 11) | 23'd39, 16'h0, 2'b00);
      reqValid = 1'b0;
      readBack(16'hA027, "stream read");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule